// File: doc/BRIEF.md
# Data Cache Line Fill Formatter

This block turns one 16-byte data cache fill into the write words for a data array, a tag array and a per-set valid-bit store. A fill arrives as a physical address, sixteen data bytes, a target way and a one-cycle valid strobe. One clock later the block presents a single registered write. That write carries the set index taken from the middle address bits, the way, the unchanged data bytes with one even parity bit per byte, a tag word with its own parity bit, and a strobe that sets the valid bit for that set and way.

The fill must be aligned to a 16-byte line. A fill whose low four address bits are not all zero produces no write of any kind. It raises a one-cycle alignment error flag instead. The arrays, the way replacement choice and the physical placement of bits in the arrays lie outside this block.

Top module: `dcache_fill_fmt`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en`, `vset_en` and `align_err` are all 0.
- R2: An aligned fill (`fill_vld`=1, `fill_addr[3:0]`=0) sampled at a clock edge drives `wr_en` high for exactly the following cycle, with `wr_index` = `fill_addr[10:4]` and `wr_way` = `fill_way`.
- R3: During that write cycle `wr_data` equals `fill_data` bit for bit. Byte i is `fill_data[8*i+7:8*i]`.
- R4: During that write cycle, bit (15 - i) of `wr_par` is the even parity of data byte i, meaning the XOR of its eight bits. Byte 0 parity is in bit 15 and byte 15 parity is in bit 0.
- R5: During that write cycle `tag_word[28:0]` = `fill_addr[39:11]` and `tag_word[29]` is the XOR of those 29 bits, so that the 30-bit word has even parity.
- R6: `vset_en` is high in exactly the cycles where `wr_en` is high. The valid bit it sets is the one selected by the same `wr_index` and `wr_way`.
- R7: A fill with `fill_addr[3:0]` not zero sets `align_err` for the following cycle only. In that cycle `wr_en` and `vset_en` stay 0, and all write fields keep their previous values.
- R8: In a cycle that follows no fill, `wr_en`, `vset_en` and `align_err` are 0, and `wr_index`, `wr_way`, `wr_data`, `wr_par` and `tag_word` hold their previous values.
- R9: Fills on consecutive cycles each produce their own write on consecutive cycles, with no cycle lost between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | Fill request strobe |
| fill_addr | input | 40 | Physical address of the line |
| fill_data | input | 128 | Sixteen fill bytes, byte i at bits 8i+7:8i |
| fill_way | input | 2 | Way that receives the line |
| wr_en | output | 1 | Data and tag array write strobe |
| wr_index | output | 7 | Set index for all three writes |
| wr_way | output | 2 | Way for all three writes |
| wr_data | output | 128 | Data array write bytes |
| wr_par | output | 16 | Per-byte parity, byte i at bit 15-i |
| tag_word | output | 30 | Tag in bits 28:0, tag parity in bit 29 |
| vset_en | output | 1 | Valid-bit set strobe |
| align_err | output | 1 | Misaligned fill flag |

## Verification
A wrong register inside the block shows up at the ports in the cycle right after the fill that exposes it. A stuck or misrouted index or way bit gives a wrong `wr_index` or `wr_way` for some set/way pair. A swapped parity position gives a `wr_par` that no longer matches the reversed-byte rule on data whose bytes differ in parity. A wrong enable path gives a write strobe after a misaligned or absent fill, or a missing strobe after a good one. Sweeping every set and every way with varied data, and every nonzero low-address pattern, brings each of these faults to a port within one cycle.

// File: rtl/dcache_fill_fmt.sv
module dcache_fill_fmt #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 16,
  parameter int WAY_W      = 2,
  parameter int SET_W      = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fill_vld,
  input  logic [ADDR_W-1:0]             fill_addr,
  input  logic [8*LINE_BYTES-1:0]       fill_data,
  input  logic [WAY_W-1:0]              fill_way,
  output logic                          wr_en,
  output logic [SET_W-1:0]              wr_index,
  output logic [WAY_W-1:0]              wr_way,
  output logic [8*LINE_BYTES-1:0]       wr_data,
  output logic [LINE_BYTES-1:0]         wr_par,
  output logic [ADDR_W-SET_W-$clog2(LINE_BYTES):0] tag_word,
  output logic                          vset_en,
  output logic                          align_err
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_LO = OFF_W + SET_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int DATA_W = 8 * LINE_BYTES;

  logic                 aligned;
  logic                 take;
  logic [LINE_BYTES-1:0] byte_par;
  logic [TAG_W-1:0]     tag_bits;

  assign aligned  = (fill_addr[OFF_W-1:0] == '0);
  assign take     = fill_vld && aligned;
  assign tag_bits = fill_addr[ADDR_W-1:TAG_LO];

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_bpar
    assign byte_par[LINE_BYTES-1-i] = ^fill_data[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      vset_en   <= 1'b0;
      align_err <= 1'b0;
    end else begin
      wr_en     <= take;
      vset_en   <= take;
      align_err <= fill_vld && !aligned;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_index <= '0;
      wr_way   <= '0;
      wr_data  <= '0;
      wr_par   <= '0;
      tag_word <= '0;
    end else if (take) begin
      wr_index <= fill_addr[TAG_LO-1:OFF_W];
      wr_way   <= fill_way;
      wr_data  <= fill_data;
      wr_par   <= byte_par;
      tag_word <= {^tag_bits, tag_bits};
    end
  end

  AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!wr_en && !vset_en)); // R7
  AST_ERR_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $stable(wr_data) && $stable(tag_word)); // R7
  AST_WRITE_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(fill_vld)); // R2
  AST_INDEX_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_index == $past(fill_addr[TAG_LO-1:OFF_W])); // R2
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data == $past(fill_data)); // R3
  AST_LINE_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (^{wr_data, wr_par}) == 1'b0); // R4
  AST_TAG_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (^tag_word) == 1'b0); // R5
  AST_VSET_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    vset_en == wr_en); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $stable(wr_index) && $stable(wr_par)); // R8

  logic unused_w;
  assign unused_w = ^DATA_W;
endmodule

// File: tb/dcache_fill_fmt_test.sv
module dcache_fill_fmt_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_vld = 1'b0;
  logic [39:0]  fill_addr = '0;
  logic [127:0] fill_data = '0;
  logic [1:0]   fill_way = '0;
  logic         wr_en, vset_en, align_err;
  logic [6:0]   wr_index;
  logic [1:0]   wr_way;
  logic [127:0] wr_data;
  logic [15:0]  wr_par;
  logic [29:0]  tag_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_fill_fmt uut (
    .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_addr(fill_addr),
    .fill_data(fill_data), .fill_way(fill_way), .wr_en(wr_en),
    .wr_index(wr_index), .wr_way(wr_way), .wr_data(wr_data), .wr_par(wr_par),
    .tag_word(tag_word), .vset_en(vset_en), .align_err(align_err)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_par(input logic [127:0] d);
    logic [15:0] p = '0;
    for (int i = 0; i < 16; i++) begin
      logic b = 1'b0;
      for (int j = 0; j < 8; j++) b = b ^ d[8*i+j];
      p[15-i] = b;
    end
    return p;
  endfunction

  function automatic logic [29:0] exp_tag(input logic [39:0] a);
    logic [28:0] t = a[39:11];
    int ones = 0;
    for (int j = 0; j < 29; j++) ones += int'(t[j]);
    return {ones[0], t};
  endfunction

  function automatic logic [127:0] make_data(input int k);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[8*i +: 8] = 8'((k * 37 + i * 11 + i * k) & 255);
    return d;
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [39:0]  pa;
    logic [127:0] pd;
    logic [1:0]   pw;
    repeat (3) @(negedge clk);
    chk("R1 wr_en in reset", 128'(wr_en), 128'd0);
    chk("R1 vset_en in reset", 128'(vset_en), 128'd0);
    chk("R1 align_err in reset", 128'(align_err), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_en after reset", 128'(wr_en), 128'd0);
    chk("R1 align_err after reset", 128'(align_err), 128'd0);

    // R9: back-to-back sweep of every set and way
    pa = '0; pd = '0; pw = '0;
    for (int k = 0; k < 512; k++) begin
      logic [28:0] t;
      t = 29'(k * 32'h0123_4567 + 32'h0ABC_DEF1);
      fill_vld  = 1'b1;
      fill_addr = {t, 7'(k >> 2), 4'h0};
      fill_way  = 2'(k);
      fill_data = make_data(k);
      pa = fill_addr; pd = fill_data; pw = fill_way;
      @(negedge clk);
      chk("R2 wr_en pulse", 128'(wr_en), 128'd1);
      chk("R2 wr_index", 128'(wr_index), 128'(pa[10:4]));
      chk("R2 wr_way", 128'(wr_way), 128'(pw));
      chk("R3 wr_data", wr_data, pd);
      chk("R4 wr_par", 128'(wr_par), 128'(exp_par(pd)));
      chk("R5 tag_word", 128'(tag_word), 128'(exp_tag(pa)));
      chk("R6 vset_en", 128'(vset_en), 128'd1);
      chk("R9 no align_err", 128'(align_err), 128'd0);
    end

    // R8: idle cycle after a fill
    fill_vld = 1'b0;
    fill_addr = 40'hFF_FFFF_FFF0;
    fill_data = ~pd;
    @(negedge clk);
    chk("R8 wr_en idle", 128'(wr_en), 128'd0);
    chk("R8 vset_en idle", 128'(vset_en), 128'd0);
    chk("R8 align_err idle", 128'(align_err), 128'd0);
    chk("R8 wr_data held", wr_data, pd);
    chk("R8 wr_index held", 128'(wr_index), 128'(pa[10:4]));
    chk("R8 tag_word held", 128'(tag_word), 128'(exp_tag(pa)));

    // R7: every nonzero low nibble
    for (int m = 1; m < 16; m++) begin
      fill_vld  = 1'b1;
      fill_addr = {29'h1555_AAAA, 7'h2A, 4'(m)};
      fill_way  = 2'(~pw);
      fill_data = make_data(m + 999);
      @(negedge clk);
      chk("R7 align_err", 128'(align_err), 128'd1);
      chk("R7 no wr_en", 128'(wr_en), 128'd0);
      chk("R7 no vset_en", 128'(vset_en), 128'd0);
      chk("R7 wr_data held", wr_data, pd);
      chk("R7 wr_way held", 128'(wr_way), 128'(pw));
      chk("R7 tag_word held", 128'(tag_word), 128'(exp_tag(pa)));
    end
    fill_vld = 1'b0;
    @(negedge clk);
    chk("R7 align_err one cycle", 128'(align_err), 128'd0);

    // R4: single-byte parity positions
    for (int b = 0; b < 16; b++) begin
      fill_vld  = 1'b1;
      fill_addr = 40'h00_0000_0800;
      fill_way  = 2'd0;
      fill_data = 128'h1 << (8 * b);
      @(negedge clk);
      chk("R4 reversed parity position", 128'(wr_par), 128'(16'h1 << (15 - b)));
    end
    fill_vld = 1'b0;
    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule